// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Arbiter with Nested Completion

This block sits between an interrupt distributor and a set of processors. For every CPU it walks the table of interrupt IDs, finds the enabled, pending ID with the numerically lowest priority value, and decides whether that ID may interrupt the CPU. The decision depends on the CPU's priority mask and on the priority of the interrupt the CPU is already servicing. The result drives one request line per CPU.

Each CPU sees a small register window. It has an enable, an 8-bit priority mask, a binary-point register that reads as zero, an acknowledge register, an end-of-interrupt register, the running priority and the highest-pending ID. An acknowledge makes the chosen ID the running one and records which ID it preempted, so the IDs form a linked stack per CPU. A completion of the running ID pops that stack. A completion of a buried ID unlinks it from the chain and leaves the running priority alone. The block does not hold pending state itself. It emits one-cycle clear and set strobes, and the distributor applies them at the next clock edge.

The scan looks at one ID per clock cycle. Acknowledge and completion requests wait until a scan that began after the previous acknowledge or completion has finished. The value 1023 stands for "no interrupt", and the idle running priority is 0x100, which is below every 8-bit priority.

Top module: `irqPrioArbiter`

## Requirements
- R1: After reset, every CPU reads enable 0, mask 0xF0, running priority 0x100 and highest-pending 1023, and every request line is low.
- R2: Among enabled, pending IDs the lowest priority value wins. On a tie the lowest ID wins.
- R3: The winner is reported as highest-pending (offset 0x18) only if its priority is less than or equal to the CPU mask (offset 0x04). Otherwise 1023 is reported.
- R4: A CPU's request line is high only when a highest-pending ID exists and its priority is strictly less than the CPU's running priority (offset 0x14).
- R5: While the global distributor enable or the CPU enable (bit 0 at offset 0x00) is low, highest-pending reads 1023 and the line stays low.
- R6: A read of the acknowledge register (offset 0x0C) returns 1023 and changes no state when no ID is pending or the candidate's priority is not below the running priority.
- R7: A successful acknowledge returns the ID and makes it running, with its priority as running priority. It pulses the pending-clear strobe for that ID on every CPU when the ID's one-of-N model bit is 1. Otherwise it pulses the strobe only for the acknowledging CPU. The strobe bit index is cpu*NUM_IDS+id.
- R8: A write to the completion register (offset 0x10, ID in bits 9:0) while nothing is running is ignored: no set strobe is pulsed and the running priority stays 0x100.
- R9: A completion of an ID that is level-sensitive, enabled, has its line high and targets this CPU pulses the pending-set strobe for that CPU and ID.
- R10: A completion of the running ID makes its predecessor running again and restores that predecessor's priority.
- R11: A completion of an ID that is not running removes it from the chain and leaves the running priority unchanged. A later completion of the running ID then skips the removed entry.
- R12: The binary-point register (offset 0x08) reads 0 and ignores writes. The mask keeps only bits 7:0 of a write.
- R13: An acknowledge or completion issued right after another one is not answered until a full scan of NUM_IDS cycles has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| distEnable | input | 1 | Global distributor enable |
| idEnable | input | NUM_IDS | Per-ID enable |
| idPending | input | NUM_CPUS*NUM_IDS | Pending flags, bit cpu*NUM_IDS+id |
| idPrio | input | NUM_IDS*8 | Priority per ID, bits id*8+7:id*8 |
| idOneOfN | input | NUM_IDS | 1: acknowledge clears pending on all CPUs |
| idLevel | input | NUM_IDS | 1: level-sensitive ID |
| idLineHigh | input | NUM_IDS | Current level of each ID's source line |
| idTarget | input | NUM_CPUS*NUM_IDS | Target flags, bit cpu*NUM_IDS+id |
| regReq | input | 1 | Register access request, held until regAck |
| regCpu | input | CPU_W | CPU whose window is accessed |
| regWe | input | 1 | 1 write, 0 read |
| regAddr | input | 8 | Byte offset in the CPU window |
| regWdata | input | 10 | Write data |
| regAck | output | 1 | One-cycle completion of the access |
| regRdata | output | 32 | Read data, valid with regAck |
| irqOut | output | NUM_CPUS | Request line per CPU |
| pendClr | output | NUM_CPUS*NUM_IDS | Pending-clear strobes |
| pendSet | output | NUM_CPUS*NUM_IDS | Pending-set strobes |

## Verification
The assertions assume that each ID's priority does not change while that ID sits in a CPU's running chain. They also assume a register request is held steady until its acknowledge and dropped in the cycle that follows. The bench keeps every priority fixed after reset. It releases each request on the first falling edge that shows the acknowledge. Its own distributor model applies the clear and set strobes at the next rising edge, which matches what the restart of the scan expects.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_ID = 10'h3FF;
  localparam logic [8:0] IDLE_PRIO = 9'h100;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_BPT   = 8'h08;
  localparam logic [7:0] OFF_ACK   = 8'h0C;
  localparam logic [7:0] OFF_EOI   = 8'h10;
  localparam logic [7:0] OFF_RPRI  = 8'h14;
  localparam logic [7:0] OFF_HPEND = 8'h18;

  typedef struct packed {
    logic restart;
  } scanCtl_t;
endpackage

// File: rtl/prioScanDp.sv
module prioScanDp import irqArbPkg::*; #(
  parameter int NUM_IDS = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanCtl_t              ctl,
  input  logic [NUM_IDS-1:0]    idEnable,
  input  logic [NUM_IDS-1:0]    pendRow,
  input  logic [NUM_IDS*8-1:0]  idPrio,
  output logic [ID_W-1:0]       bestId,
  output logic [8:0]            bestPrio,
  output logic                  fresh
);
  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;

  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  runId, nextId;
  logic [8:0]       runPrio, nextPrio, candPrio;
  logic             take, lastIdx;

  always_comb begin
    candPrio = {1'b0, idPrio[{idx, 3'b000} +: 8]};
    take     = idEnable[idx] && pendRow[idx] && (candPrio < runPrio);
    nextId   = take ? ID_W'(idx) : runId;
    nextPrio = take ? candPrio : runPrio;
    lastIdx  = (idx == IDX_W'(NUM_IDS - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      runId    <= NO_ID;
      runPrio  <= IDLE_PRIO;
      bestId   <= NO_ID;
      bestPrio <= IDLE_PRIO;
      fresh    <= 1'b0;
    end else if (ctl.restart) begin
      idx     <= '0;
      runId   <= NO_ID;
      runPrio <= IDLE_PRIO;
      fresh   <= 1'b0;
    end else if (lastIdx) begin
      idx      <= '0;
      runId    <= NO_ID;
      runPrio  <= IDLE_PRIO;
      bestId   <= nextId;
      bestPrio <= nextPrio;
      fresh    <= 1'b1;
    end else begin
      idx     <= idx + 1'b1;
      runId   <= nextId;
      runPrio <= nextPrio;
    end
  end

  // R13
  restart_clears_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> !fresh);

  // R2
  best_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bestId == NO_ID) == (bestPrio == IDLE_PRIO));
endmodule

// File: rtl/cpuIfCtrl.sv
module cpuIfCtrl import irqArbPkg::*; #(
  parameter int NUM_IDS = 32,
  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  distEnable,
  input  logic [NUM_IDS-1:0]    idEnable,
  input  logic [NUM_IDS-1:0]    idOneOfN,
  input  logic [NUM_IDS-1:0]    idLevel,
  input  logic [NUM_IDS-1:0]    idLineHigh,
  input  logic [NUM_IDS-1:0]    targetRow,
  input  logic [NUM_IDS*8-1:0]  idPrio,
  input  logic [ID_W-1:0]       bestId,
  input  logic [8:0]            bestPrio,
  input  logic                  fresh,
  output scanCtl_t              scanCtl,
  input  logic                  reqSel,
  input  logic                  regWe,
  input  logic [7:0]            regAddr,
  input  logic [9:0]            regWdata,
  output logic                  ackQ,
  output logic [31:0]           rdataQ,
  output logic                  irq,
  output logic                  clrStb,
  output logic                  clrAll,
  output logic [IDX_W-1:0]      clrIdx,
  output logic                  setStb,
  output logic [IDX_W-1:0]      setIdx
);
  typedef enum logic {ST_IDLE, ST_WALK} st_t;

  st_t              state;
  logic             cpuEnQ;
  logic [7:0]       maskQ;
  logic [ID_W-1:0]  runIdQ, eoiHold;
  logic [8:0]       runPrioQ, prevPrio;
  logic [ID_W-1:0]  prevOf [NUM_IDS];
  logic [IDX_W-1:0] walkPtr;
  logic [ID_W-1:0]  hpId, eoiId, prevRun, walkNxt;
  logic             isAck, isEoi, svc, ackTake, eoiValid, eoiRun, inRange;
  logic [31:0]      rdNext;

  always_comb begin
    hpId = (distEnable && cpuEnQ && bestId != NO_ID && bestPrio <= {1'b0, maskQ})
           ? bestId : NO_ID;
    irq      = (hpId != NO_ID) && (bestPrio < runPrioQ);
    isAck    = !regWe && regAddr == OFF_ACK;
    isEoi    = regWe && regAddr == OFF_EOI;
    svc      = reqSel && !ackQ && state == ST_IDLE && (!(isAck || isEoi) || fresh);
    ackTake  = svc && isAck && irq;
    eoiId    = regWdata;
    eoiValid = svc && isEoi && runIdQ != NO_ID;
    eoiRun   = eoiValid && eoiId == runIdQ;
    inRange  = eoiId < ID_W'(NUM_IDS);
    prevRun  = prevOf[runIdQ[IDX_W-1:0]];
    prevPrio = (prevRun == NO_ID) ? IDLE_PRIO
               : {1'b0, idPrio[{prevRun[IDX_W-1:0], 3'b000} +: 8]};
    walkNxt  = prevOf[walkPtr];

    scanCtl.restart = ackTake || eoiValid;
    clrStb = ackTake;
    clrIdx = bestId[IDX_W-1:0];
    clrAll = idOneOfN[bestId[IDX_W-1:0]];
    setIdx = eoiId[IDX_W-1:0];
    setStb = eoiValid && inRange && idLevel[setIdx] && idEnable[setIdx]
             && idLineHigh[setIdx] && targetRow[setIdx];

    case (regAddr)
      OFF_CTRL:  rdNext = {31'b0, cpuEnQ};
      OFF_MASK:  rdNext = {24'b0, maskQ};
      OFF_ACK:   rdNext = {22'b0, ackTake ? bestId : NO_ID};
      OFF_RPRI:  rdNext = {23'b0, runPrioQ};
      OFF_HPEND: rdNext = {22'b0, hpId};
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cpuEnQ   <= 1'b0;
      maskQ    <= 8'hF0;
      runIdQ   <= NO_ID;
      runPrioQ <= IDLE_PRIO;
      eoiHold  <= NO_ID;
      walkPtr  <= '0;
      ackQ     <= 1'b0;
      rdataQ   <= '0;
      for (int i = 0; i < NUM_IDS; i++) prevOf[i] <= NO_ID;
    end else begin
      ackQ <= 1'b0;
      if (svc) begin
        rdataQ <= rdNext;
        if (regWe && regAddr == OFF_CTRL) cpuEnQ <= regWdata[0];
        if (regWe && regAddr == OFF_MASK) maskQ <= regWdata[7:0];
        if (ackTake) begin
          prevOf[bestId[IDX_W-1:0]] <= runIdQ;
          runIdQ   <= bestId;
          runPrioQ <= bestPrio;
        end
        if (eoiRun) begin
          runIdQ   <= prevRun;
          runPrioQ <= prevPrio;
        end
        if (eoiValid && !eoiRun) begin
          state   <= ST_WALK;
          walkPtr <= runIdQ[IDX_W-1:0];
          eoiHold <= eoiId;
        end else begin
          ackQ <= 1'b1;
        end
      end else if (state == ST_WALK) begin
        if (walkNxt == NO_ID) begin
          state <= ST_IDLE;
          ackQ  <= 1'b1;
        end else if (walkNxt == eoiHold) begin
          prevOf[walkPtr] <= prevOf[eoiHold[IDX_W-1:0]];
          state <= ST_IDLE;
          ackQ  <= 1'b1;
        end else begin
          walkPtr <= walkNxt[IDX_W-1:0];
        end
      end
    end
  end

  // R1
  run_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runIdQ == NO_ID) == (runPrioQ == IDLE_PRIO));

  // R7
  ack_takes_best_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |=> (runIdQ == $past(bestId)) && (runPrioQ == $past(bestPrio)));

  // R10
  eoi_pops_chk: assert property (@(posedge clk) disable iff (!rstN)
    eoiRun |=> runIdQ == $past(prevRun));

  // R8
  eoi_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svc && isEoi && runIdQ == NO_ID) |=> runPrioQ == IDLE_PRIO);

  // R13
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackQ |=> !ackQ);
endmodule

// File: rtl/irqPrioArbiter.sv
module irqPrioArbiter import irqArbPkg::*; #(
  parameter int NUM_IDS  = 32,
  parameter int NUM_CPUS = 2,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int IDX_W = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         distEnable,
  input  logic [NUM_IDS-1:0]           idEnable,
  input  logic [NUM_CPUS*NUM_IDS-1:0]  idPending,
  input  logic [NUM_IDS*8-1:0]         idPrio,
  input  logic [NUM_IDS-1:0]           idOneOfN,
  input  logic [NUM_IDS-1:0]           idLevel,
  input  logic [NUM_IDS-1:0]           idLineHigh,
  input  logic [NUM_CPUS*NUM_IDS-1:0]  idTarget,
  input  logic                         regReq,
  input  logic [CPU_W-1:0]             regCpu,
  input  logic                         regWe,
  input  logic [7:0]                   regAddr,
  input  logic [9:0]                   regWdata,
  output logic                         regAck,
  output logic [31:0]                  regRdata,
  output logic [NUM_CPUS-1:0]          irqOut,
  output logic [NUM_CPUS*NUM_IDS-1:0]  pendClr,
  output logic [NUM_CPUS*NUM_IDS-1:0]  pendSet
);
  logic [NUM_CPUS-1:0] ackArr, clrStb, clrAll, setStb;
  logic [31:0]         rdataArr [NUM_CPUS];
  logic [IDX_W-1:0]    clrIdx [NUM_CPUS];
  logic [IDX_W-1:0]    setIdx [NUM_CPUS];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    scanCtl_t        ctl;
    logic [ID_W-1:0] bestId;
    logic [8:0]      bestPrio;
    logic            fresh;

    prioScanDp #(.NUM_IDS(NUM_IDS)) dp_i (
      .clk(clk), .rstN(rstN), .ctl(ctl), .idEnable(idEnable),
      .pendRow(idPending[c*NUM_IDS +: NUM_IDS]), .idPrio(idPrio),
      .bestId(bestId), .bestPrio(bestPrio), .fresh(fresh)
    );

    cpuIfCtrl #(.NUM_IDS(NUM_IDS)) ctrl_i (
      .clk(clk), .rstN(rstN), .distEnable(distEnable), .idEnable(idEnable),
      .idOneOfN(idOneOfN), .idLevel(idLevel), .idLineHigh(idLineHigh),
      .targetRow(idTarget[c*NUM_IDS +: NUM_IDS]), .idPrio(idPrio),
      .bestId(bestId), .bestPrio(bestPrio), .fresh(fresh), .scanCtl(ctl),
      .reqSel(regReq && regCpu == CPU_W'(c)), .regWe(regWe), .regAddr(regAddr),
      .regWdata(regWdata), .ackQ(ackArr[c]), .rdataQ(rdataArr[c]), .irq(irqOut[c]),
      .clrStb(clrStb[c]), .clrAll(clrAll[c]), .clrIdx(clrIdx[c]),
      .setStb(setStb[c]), .setIdx(setIdx[c])
    );
  end

  always_comb begin
    pendClr = '0;
    pendSet = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (clrStb[c])
        for (int k = 0; k < NUM_CPUS; k++)
          if (clrAll[c] || k == c) pendClr[k*NUM_IDS + int'(clrIdx[c])] = 1'b1;
      if (setStb[c]) pendSet[c*NUM_IDS + int'(setIdx[c])] = 1'b1;
    end
  end

  assign regAck   = |ackArr;
  assign regRdata = rdataArr[regCpu];
endmodule

// File: tb/irqPrioArbiter_tb_top.sv
module irqPrioArbiter_tb_top;
  localparam int N = 32;
  localparam int C = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic             distEnable = 1'b0;
  logic [N-1:0]     idEnable = '1;
  logic [C*N-1:0]   pendQ, tbSet = '0;
  logic [N*8-1:0]   idPrio;
  logic [N-1:0]     idOneOfN = '0, idLevel = '0, idLineHigh = '0;
  logic [C*N-1:0]   idTarget = '0;
  logic             regReq = 1'b0, regWe = 1'b0;
  logic [0:0]       regCpu = '0;
  logic [7:0]       regAddr = '0;
  logic [9:0]       regWdata = '0;
  logic             regAck;
  logic [31:0]      regRdata;
  logic [C-1:0]     irqOut;
  logic [C*N-1:0]   pendClr, pendSet, seenClr, seenSet;
  logic             seenRst = 1'b0;
  logic [7:0]       prioA [N];

  int nChecks = 0, nFail = 0;
  bit done = 0;

  typedef struct { bit chk; logic [31:0] exp; string tag; } item_t;
  item_t expQ[$];
  item_t popIt;

  irqPrioArbiter #(.NUM_IDS(N), .NUM_CPUS(C)) dut_i (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .idEnable(idEnable),
    .idPending(pendQ), .idPrio(idPrio), .idOneOfN(idOneOfN), .idLevel(idLevel),
    .idLineHigh(idLineHigh), .idTarget(idTarget), .regReq(regReq), .regCpu(regCpu),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck),
    .regRdata(regRdata), .irqOut(irqOut), .pendClr(pendClr), .pendSet(pendSet)
  );

  always_comb for (int i = 0; i < N; i++) idPrio[i*8 +: 8] = prioA[i];

  // distributor model: applies strobes at the next edge
  always @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else pendQ <= (pendQ & ~pendClr) | pendSet | tbSet;
    seenClr <= seenRst ? '0 : (seenClr | pendClr);
    seenSet <= seenRst ? '0 : (seenSet | pendSet);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as responses arrive
  always @(negedge clk) begin
    if (rstN && regAck) begin
      if (expQ.size() == 0) check(0, "R13 unexpected ack", 1, 0);
      else begin
        popIt = expQ.pop_front();
        if (popIt.chk) check(regRdata == popIt.exp, popIt.tag, regRdata, popIt.exp);
      end
    end
  end

  task automatic xfer(input int cpu, input bit we, input logic [7:0] addr, input logic [9:0] wd,
                      input bit doChk, input logic [31:0] exp, input string tag, output int lat);
    item_t it;
    it.chk = doChk; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    regCpu = cpu[0:0]; regWe = we; regAddr = addr; regWdata = wd; regReq = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!regAck);
    regReq = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [7:0] addr, input logic [31:0] exp, input string tag);
    int l;
    xfer(cpu, 1'b0, addr, '0, 1'b1, exp, tag, l);
  endtask

  task automatic wr(input int cpu, input logic [7:0] addr, input logic [9:0] wd);
    int l;
    xfer(cpu, 1'b1, addr, wd, 1'b0, '0, "", l);
  endtask

  task automatic settle();
    repeat (2*N + 4) @(negedge clk);
  endtask

  task automatic setPend(input int cpu, input int id);
    @(negedge clk); tbSet = '0; tbSet[cpu*N + id] = 1'b1;
    @(negedge clk); tbSet = '0;
  endtask

  task automatic clearSeen();
    @(negedge clk); seenRst = 1'b1;
    @(negedge clk); seenRst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i < N; i++) prioA[i] = 8'hC0;
    prioA[5] = 8'h40; prioA[9] = 8'h20; prioA[12] = 8'h20; prioA[3] = 8'h10; prioA[1] = 8'h08;
    idOneOfN[9] = 1'b1;
    idLevel[5] = 1'b1; idLineHigh[5] = 1'b1; idTarget[5] = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(0, 8'h00, 0, "R1 ctrl");
    rd(0, 8'h04, 8'hF0, "R1 mask");
    rd(0, 8'h14, 9'h100, "R1 running prio");
    rd(0, 8'h18, 1023, "R1 highest pending");
    check(irqOut == 2'b00, "R1 irq lines", irqOut, 0);

    distEnable = 1'b1;
    wr(0, 8'h00, 10'd1);
    setPend(0, 5); setPend(0, 9); setPend(0, 12); setPend(1, 9);
    settle();
    // R2 tie at 0x20 between 9 and 12 -> 9
    rd(0, 8'h18, 9, "R2 lowest prio lowest id");
    check(irqOut[0] == 1'b1, "R4 irq raised", irqOut[0], 1);
    // R5 cpu1 disabled
    check(irqOut[1] == 1'b0, "R5 cpu1 disabled irq", irqOut[1], 0);
    rd(1, 8'h18, 1023, "R5 cpu1 disabled hp");

    // R3 mask
    wr(0, 8'h04, 10'h10);
    rd(0, 8'h18, 1023, "R3 masked out");
    check(irqOut[0] == 1'b0, "R3 masked irq", irqOut[0], 0);
    wr(0, 8'h04, 10'h20);
    rd(0, 8'h18, 9, "R3 equal to mask allowed");
    wr(0, 8'h04, 10'hF0);

    // R5 distributor disable
    distEnable = 1'b0;
    rd(0, 8'h18, 1023, "R5 dist disabled hp");
    check(irqOut[0] == 1'b0, "R5 dist disabled irq", irqOut[0], 0);
    distEnable = 1'b1;

    // R7 acknowledge with one-of-N model
    clearSeen();
    rd(0, 8'h0C, 9, "R7 ack id");
    check(seenClr == ((64'd1 << 9) | (64'd1 << (N + 9))), "R7 one-of-N clear all cpus", 0, 0);
    // R13 + R6: immediate second ack stalls a full scan, then 12 is not below 0x20
    xfer(0, 1'b0, 8'h0C, '0, 1'b1, 1023, "R6 equal prio ack", lat);
    check(lat >= N, "R13 ack stall", lat, N);
    rd(0, 8'h14, 8'h20, "R7 running prio");
    settle();
    rd(0, 8'h18, 12, "R4 hp while running");
    check(irqOut[0] == 1'b0, "R4 not below running", irqOut[0], 0);

    // R7 per-CPU clear
    setPend(0, 3);
    settle();
    check(irqOut[0] == 1'b1, "R4 preempting irq", irqOut[0], 1);
    clearSeen();
    rd(0, 8'h0C, 3, "R7 nested ack");
    check(seenClr == (64'd1 << 3), "R7 clear this cpu only", 0, 0);
    rd(0, 8'h14, 8'h10, "R7 nested running prio");

    // R11 complete buried 9, then running 3 returns to idle
    wr(0, 8'h10, 10'd9);
    rd(0, 8'h14, 8'h10, "R11 running prio kept");
    wr(0, 8'h10, 10'd3);
    rd(0, 8'h14, 9'h100, "R11 spliced chain");

    // R10 pop to predecessor
    settle();
    rd(0, 8'h0C, 12, "R10 ack 12");
    setPend(0, 1);
    settle();
    rd(0, 8'h0C, 1, "R10 ack 1");
    wr(0, 8'h10, 10'd1);
    rd(0, 8'h14, 8'h20, "R10 predecessor prio");
    wr(0, 8'h10, 10'd12);
    rd(0, 8'h14, 9'h100, "R10 back to idle");

    // R8 completion with nothing running
    clearSeen();
    wr(0, 8'h10, 10'd5);
    check(seenSet == '0, "R8 no set strobe", 0, 0);
    rd(0, 8'h14, 9'h100, "R8 running prio unchanged");

    // R9 level re-pend
    settle();
    rd(0, 8'h0C, 5, "R9 ack 5");
    clearSeen();
    wr(0, 8'h10, 10'd5);
    check(seenSet == (64'd1 << 5), "R9 re-pend strobe", 0, 0);

    // R12 binary point and mask width
    wr(0, 8'h08, 10'd7);
    rd(0, 8'h08, 0, "R12 binary point");
    wr(0, 8'h04, 10'h3FF);
    rd(0, 8'h04, 8'hFF, "R12 mask width");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule